// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Programmable Watermarks

This block is a first-in first-out buffer whose write side and read side run on clocks that have no fixed relation to each other. Words of nine bits go in on the write clock and come out on the read clock, in the order they were written. The buffer depth is a power-of-two parameter. Each side keeps its own binary pointer. Each pointer is sent to the other side in Gray code through a two-stage synchronizer.

Four status flags come out. Empty and almost-empty are registers in the read clock domain. Full and almost-full are registers in the write clock domain. Each flag is computed from the local pointer and the synchronized copy of the remote pointer. Because of this, a change caused by the other side shows up a few edges late, and always on the conservative side. The almost-empty and almost-full thresholds default to seven words from each end. While the buffer is idle after reset, they can be reprogrammed through a separate load strobe. Each threshold is loaded in two parts taken from the data input.

Top module: `dual_clock_prog_fifo`

## Requirements
- R1: While `rstN` is low (asynchronous), `empty` and `almostEmpty` read 1, `full` and `almostFull` read 0, `rdData` reads 0, and both thresholds return to 7.
- R2: A rising `wrClk` edge with `wrEnN` low, `loadEnN` high and `full` low stores `wrData`. A rising `rdClk` edge with `rdEnN` low and `empty` low places the oldest stored word on `rdData` at that same edge. Words leave in the order they were stored.
- R3: A write attempted while `full` is high is ignored: nothing is stored and the write pointer does not move.
- R4: A read attempted while `empty` is high is ignored: `rdData` keeps its value and the read pointer does not move.
- R5: Once both sides have been idle for several edges, `empty` is 1 exactly when no words are stored, and `full` is 1 exactly when DEPTH words are stored.
- R6: Once settled, `almostEmpty` is 1 while the stored count is at most the empty-side threshold n, and `almostFull` is 1 while the number of free slots is at most the full-side threshold m. Both thresholds are 7 after reset.
- R7: Each rising `wrClk` edge with `loadEnN` low loads one threshold part. The parts go in the order n-low, n-high, m-low, m-high and then wrap. Threshold width is W = log2(DEPTH) and P = ceil(W/2). A low part copies `wrData[P-1:0]` into threshold bits [P-1:0]. A high part copies `wrData[W-P-1:0]` into bits [W-1:P]. For the default DEPTH of 16, P = 2 and both parts are 2 bits. Loads are used only while the buffer is idle after reset.
- R8: On an edge where `loadEnN` is low, `wrEnN` has no effect and no word is stored.
- R9: `empty` and `almostEmpty` change only at rising `rdClk` edges. `full` and `almostFull` change only at rising `wrClk` edges. A change caused by the other side can therefore lag by synchronizer edges.
- R10: After one word is written into an empty buffer, `empty` falls on the second to fourth following `rdClk` edge, and the next read returns that word. The pointer copies moved across domains change by at most one bit per edge of their own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low, shared by both sides |
| wrEnN | input | 1 | Write enable, active low |
| loadEnN | input | 1 | Threshold part load strobe, active low, write clock domain |
| wrData | input | 9 | Write data; low bits also carry threshold parts |
| rdEnN | input | 1 | Read enable, active low |
| rdData | output | 9 | Registered read data |
| empty | output | 1 | No words stored (read domain) |
| almostEmpty | output | 1 | Stored count at or below threshold n (read domain) |
| full | output | 1 | DEPTH words stored (write domain) |
| almostFull | output | 1 | Free slots at or below threshold m (write domain) |

## Verification
The hardest conditions to produce from the ports are the flag values right at each threshold boundary, for thresholds loaded at run time and not only for the default. The bench loads several threshold pairs, including both extremes of zero and DEPTH-1. For each pair it fills the buffer one word at a time and drains it one word at a time, and it lets both domains settle before comparing all four flags with counts computed in the bench. The cross-domain lag is examined separately. Flags are sampled just after an edge of the opposite clock to confirm they have not moved. A long stream with unrelated clock periods and different burst patterns on each side then checks ordering while the flags are changing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Order in which threshold parts are taken by successive load strobes.
  typedef enum logic [1:0] {
    LD_AE_LO = 2'd0,
    LD_AE_HI = 2'd1,
    LD_AF_LO = 2'd2,
    LD_AF_HI = 2'd3
  } loadStep_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic       memWr;   // write domain: store wrData at wrAddr
    logic       memRd;   // read domain: fetch rdAddr into rdData
    logic [3:0] offWr;   // write domain: one-hot, indexed by loadStep_e
  } dcfStrobes_t;

  localparam int unsigned DEFAULT_OFFSET = 7;
  localparam int unsigned SYNC_STAGES    = 2;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[CHAIN_W-WIDTH-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         wrClk,
  input  logic                         rdClk,
  input  logic                         rstN,
  input  logic                         wrEnN,
  input  logic                         rdEnN,
  input  logic                         loadEnN,
  input  logic [$clog2(DEPTH)-1:0]     aeOff,
  input  logic [$clog2(DEPTH)-1:0]     afOff,
  output dcfStrobes_t                  stb,
  output logic [$clog2(DEPTH)-1:0]     wrAddr,
  output logic [$clog2(DEPTH)-1:0]     rdAddr,
  output logic                         empty,
  output logic                         almostEmpty,
  output logic                         full,
  output logic                         almostFull
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = int'(PTR_W) - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wPtr, wPtrNext, wGray, rGrayW, rPtrW, wCountNext;
  loadStep_e        loadStep;
  logic             doWrite, doLoad;

  assign doLoad     = !loadEnN;
  assign doWrite    = !wrEnN && loadEnN && !full;
  assign wPtrNext   = wPtr + PTR_W'(doWrite);
  assign rPtrW      = gray2bin(rGrayW);
  assign wCountNext = wPtrNext - rPtrW;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wPtr       <= '0;
      wGray      <= '0;
      full       <= 1'b0;
      almostFull <= 1'b0;
      loadStep   <= LD_AE_LO;
    end else begin
      wPtr       <= wPtrNext;
      wGray      <= bin2gray(wPtrNext);
      full       <= (wCountNext == DEPTH_P);
      almostFull <= ((DEPTH_P - wCountNext) <= PTR_W'(afOff));
      if (doLoad) loadStep <= loadStep_e'(loadStep + 2'd1);
    end
  end

  dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk     (wrClk),
    .rstN    (rstN),
    .asyncIn (rGray),
    .syncOut (rGrayW)
  );

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rPtr, rPtrNext, rGray, wGrayR, wPtrR, rCountNext;
  logic             doRead;

  assign doRead     = !rdEnN && !empty;
  assign rPtrNext   = rPtr + PTR_W'(doRead);
  assign wPtrR      = gray2bin(wGrayR);
  assign rCountNext = wPtrR - rPtrNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rPtr        <= '0;
      rGray       <= '0;
      empty       <= 1'b1;
      almostEmpty <= 1'b1;
    end else begin
      rPtr        <= rPtrNext;
      rGray       <= bin2gray(rPtrNext);
      empty       <= (rCountNext == '0);
      almostEmpty <= (rCountNext <= PTR_W'(aeOff));
    end
  end

  dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk     (rdClk),
    .rstN    (rstN),
    .asyncIn (wGray),
    .syncOut (wGrayR)
  );

  // ---------------- strobes to datapath ----------------
  always_comb begin
    stb       = '0;
    stb.memWr = doWrite;
    stb.memRd = doRead;
    stb.offWr = doLoad ? (4'b0001 << loadStep) : 4'b0000;
  end

  assign wrAddr = wPtr[ADDR_W-1:0];
  assign rdAddr = rPtr[ADDR_W-1:0];

  // ---------------- assertions ----------------
  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && !wrEnN) |=> (wPtr == $past(wPtr)));

  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (empty && !rdEnN) |=> (rPtr == $past(rPtr)));

  p_count_bound_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    ((wPtr - rPtrW) <= DEPTH_P));

  p_empty_in_ae_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty);

  p_full_in_af_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull);

  p_wgray_step_r10: assert property (@(posedge wrClk) disable iff (!rstN)
    ($countones(wGray ^ $past(wGray)) <= 1));

  p_rgray_step_r10: assert property (@(posedge rdClk) disable iff (!rstN)
    ($countones(rGray ^ $past(rGray)) <= 1));

endmodule

// File: rtl/dcf_store.sv
module dcf_store
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 9
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  dcfStrobes_t              stb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [$clog2(DEPTH)-1:0] aeOff,
  output logic [$clog2(DEPTH)-1:0] afOff
);

  localparam int unsigned OFF_W  = $clog2(DEPTH);
  localparam int unsigned PART_W = (OFF_W + 1) / 2;
  localparam int unsigned HI_W   = OFF_W - PART_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.memRd) rdData <= mem[rdAddr];
  end

  // Thresholds: written in the write domain, held constant while the
  // read domain uses them (loads only occur with the buffer idle).
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= OFF_W'(DEFAULT_OFFSET);
      afOff <= OFF_W'(DEFAULT_OFFSET);
    end else begin
      if (stb.offWr[LD_AE_LO]) aeOff[PART_W-1:0]     <= wrData[PART_W-1:0];
      if (stb.offWr[LD_AE_HI]) aeOff[OFF_W-1:PART_W] <= wrData[HI_W-1:0];
      if (stb.offWr[LD_AF_LO]) afOff[PART_W-1:0]     <= wrData[PART_W-1:0];
      if (stb.offWr[LD_AF_HI]) afOff[OFF_W-1:PART_W] <= wrData[HI_W-1:0];
    end
  end

  p_rd_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.memRd |=> $stable(rdData));

  p_load_onehot_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(stb.offWr));

endmodule

// File: rtl/dual_clock_prog_fifo.sv
module dual_clock_prog_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              loadEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  output logic              full,
  output logic              almostFull
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  dcfStrobes_t       stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOff, afOff;

  dcf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrEnN       (wrEnN),
    .rdEnN       (rdEnN),
    .loadEnN     (loadEnN),
    .aeOff       (aeOff),
    .afOff       (afOff),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .empty       (empty),
    .almostEmpty (almostEmpty),
    .full        (full),
    .almostFull  (almostFull)
  );

  dcf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData),
    .aeOff  (aeOff),
    .afOff  (afOff)
  );

  p_load_no_write_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadEnN |-> !stb.memWr);

endmodule

// File: tb/dual_clock_prog_fifo_bench.sv
module dual_clock_prog_fifo_bench;

  localparam int DEPTH     = 16;
  localparam int DATA_W    = 9;
  localparam int PART_W    = 2;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnN = 1'b1;
  logic rdEnN = 1'b1;
  logic loadEnN = 1'b1;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic empty, almostEmpty, full, almostFull;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int model[$];
  int aeN = 7;
  int afM = 7;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  dual_clock_prog_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dual_clock_prog_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEnN(wrEnN), .loadEnN(loadEnN),
    .wrData(wrData), .rdEnN(rdEnN), .rdData(rdData), .empty(empty),
    .almostEmpty(almostEmpty), .full(full), .almostFull(almostFull)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    int c = model.size();
    check(empty == (c == 0), req, "empty", int'(empty), int'(c == 0));
    check(almostEmpty == (c <= aeN), req, "almostEmpty", int'(almostEmpty), int'(c <= aeN));
    check(full == (c == DEPTH), req, "full", int'(full), int'(c == DEPTH));
    check(almostFull == ((DEPTH - c) <= afM), req, "almostFull",
          int'(almostFull), int'((DEPTH - c) <= afM));
  endtask

  task automatic settle();
    repeat (5) @(posedge rdClk);
    repeat (5) @(posedge wrClk);
    @(posedge rdClk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEnN = 1'b1; rdEnN = 1'b1; loadEnN = 1'b1;
    repeat (2) @(posedge wrClk);
    repeat (2) @(posedge rdClk);
    #1;
    rstN = 1'b1;
    model.delete();
    aeN = 7; afM = 7;
    settle();
  endtask

  task automatic writeWord(input int d);
    wrData = DATA_W'(d); wrEnN = 1'b0;
    @(posedge wrClk); #1;
    wrEnN = 1'b1;
    if (model.size() < DEPTH) model.push_back(d & 9'h1FF);
  endtask

  task automatic readWord(input string req);
    int prev = int'(rdData);
    rdEnN = 1'b0;
    @(posedge rdClk); #1;
    rdEnN = 1'b1;
    if (model.size() > 0) begin
      int exp = model.pop_front();
      check(int'(rdData) == exp, req, "rdData", int'(rdData), exp);
    end else begin
      check(int'(rdData) == prev, "R4", "rdData held on empty read", int'(rdData), prev);
    end
  endtask

  task automatic loadPart(input int v, input bit alsoWrite);
    wrData = DATA_W'(v); loadEnN = 1'b0; wrEnN = alsoWrite ? 1'b0 : 1'b1;
    @(posedge wrClk); #1;
    loadEnN = 1'b1; wrEnN = 1'b1;
  endtask

  task automatic loadOffsets(input int n, input int m, input bit alsoWrite);
    loadPart(n & 3, alsoWrite);
    loadPart(n >> PART_W, alsoWrite);
    loadPart(m & 3, alsoWrite);
    loadPart(m >> PART_W, alsoWrite);
    aeN = n; afM = m;
  endtask

  task automatic sweep(input int base);
    for (int i = 0; i < DEPTH; i++) begin
      writeWord(base + i * 37);
      settle();
      checkFlags("R6");
    end
    checkFlags("R5");
    writeWord(9'h1AB);          // R3: rejected, model unchanged
    settle();
    check(full == 1'b1, "R3", "full after rejected write", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      readWord("R2");
      settle();
      checkFlags("R6");
    end
    checkFlags("R5");
    readWord("R4");
    settle();
    checkFlags("R4");
  endtask

  task automatic stream(input int total);
    int sent = 0;
    int got = 0;
    fork
      begin
        int cyc = 0;
        while (sent < total) begin
          @(posedge wrClk); #1;
          cyc++;
          if (!full && (cyc % 7 != 3) && (cyc % 11 != 5)) begin
            wrData = DATA_W'(sent * 13 + 5); wrEnN = 1'b0;
            model.push_back((sent * 13 + 5) & 9'h1FF);
            sent++;
          end else begin
            wrEnN = 1'b1;
          end
        end
        @(posedge wrClk); #1;
        wrEnN = 1'b1;
      end
      begin
        int cyc = 0;
        bit pending = 0;
        while (got < total) begin
          @(posedge rdClk); #1;
          cyc++;
          if (pending) begin
            int exp = model.pop_front();
            check(int'(rdData) == exp, "R2", "stream rdData", int'(rdData), exp);
            got++;
          end
          if (got < total && !empty && (cyc % 5 != 2)) begin
            rdEnN = 1'b0; pending = 1;
          end else begin
            rdEnN = 1'b1; pending = 0;
          end
        end
        rdEnN = 1'b1;
      end
    join
  endtask

  initial begin
    int k;
    repeat (2) @(posedge wrClk);
    #1;
    // R1: reset state
    check(empty == 1'b1, "R1", "empty", int'(empty), 1);
    check(almostEmpty == 1'b1, "R1", "almostEmpty", int'(almostEmpty), 1);
    check(full == 1'b0, "R1", "full", int'(full), 0);
    check(almostFull == 1'b0, "R1", "almostFull", int'(almostFull), 0);
    check(rdData == '0, "R1", "rdData", int'(rdData), 0);
    doReset();

    // R6: default thresholds
    sweep(3);

    // R7 and R8: programmed thresholds, first load with write enable also low
    doReset();
    loadOffsets(3, 10, 1'b1);
    settle();
    checkFlags("R8");
    sweep(100);
    doReset();
    loadOffsets(0, 15, 1'b0);
    settle();
    sweep(200);
    doReset();
    loadOffsets(15, 0, 1'b0);
    settle();
    sweep(300);
    doReset();
    loadOffsets(5, 12, 1'b0);
    settle();
    sweep(400);

    // R1: reset restores default threshold 7
    doReset();
    for (int i = 0; i < 8; i++) writeWord(i + 50);
    settle();
    checkFlags("R1");
    check(almostEmpty == 1'b0, "R1", "almostEmpty with 8 stored", int'(almostEmpty), 0);

    // R9 and R10: cross-domain flag latency
    doReset();
    writeWord(9'h0F5);
    check(empty == 1'b1, "R9", "empty right after write edge", int'(empty), 1);
    k = 0;
    for (int j = 1; j <= 6; j++) begin
      @(posedge rdClk); #1;
      if (!empty) begin k = j; break; end
    end
    check(k >= 2 && k <= 4, "R10", "rdClk edges until empty falls", k, 3);
    readWord("R10");
    doReset();
    for (int i = 0; i < DEPTH; i++) writeWord(i * 3);
    settle();
    checkFlags("R5");
    readWord("R2");
    check(full == 1'b1, "R9", "full right after read edge", int'(full), 1);
    settle();
    checkFlags("R9");

    // R2: concurrent stream with unrelated clocks
    doReset();
    stream(300);
    settle();
    checkFlags("R5");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule